// File: doc/BRIEF.md
# Counter Machine Instruction Sequencer

This block runs a fixed program, supplied at elaboration time as a parameter, on a small bank of counter registers. Each cycle it fetches the instruction at the program counter, decodes it, and executes it. The instruction set has zeroing, stepping a register up or down by one, and copying between registers. It has three conditional jumps and one unconditional jump, plus stream read, stream write and halt. Every jump is relative to the address of the instruction making it.

One of the conditional instructions is a combined one. It tests a register and jumps when the register is zero. Otherwise it takes one off the register and falls through to the next instruction. Values enter through a valid/ready input stream and leave through a valid/ready output stream. When the machine stops, either at a halt or by stepping past the last instruction, it raises a sticky done flag. Register 0 is always visible on a result port.

Top module: `cm_seq`

## Requirements
- R1: After reset, `done` and `out_valid` are 0, the program counter is 0, and every register is 0, so `result` reads 0.
- R2: The instruction word is {op[23:20], ra[19:17], rb[16:14], off[13:0] two's complement}. Op 0 sets ra to 0. Op 1 adds one to ra, wrapping modulo 2^16.
- R3: Op 2 subtracts one from ra, and ra stays at 0 when it is already 0.
- R4: Op 3 copies rb into ra.
- R5: Op 4 jumps by off when ra is 0. Op 5 jumps by off when ra equals rb. Op 7 always jumps by off. A jump that is not taken, and every non-jump instruction, go to PC+1. Negative offsets jump backward.
- R6: Op 6 jumps by off when ra is 0. Otherwise it decrements ra and goes to PC+1.
- R7: `done` rises when op 10 (halt) executes, or when the next PC would fall outside the program. Once high, it stays high until reset.
- R8: Op 8 holds `in_ready` high and stalls until `in_valid` is seen. It then loads `in_data` into ra and moves on.
- R9: Op 9 drives `out_valid` with ra on `out_data`. It holds both steady and stalls until `out_ready` is seen.
- R10: `result` always shows register 0.
- R11: Ops 11 to 15 change no register and go to PC+1.
- R12: While `done` is high, `in_ready` and `out_valid` stay low. No input is taken and no output is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input stream value present |
| in_ready | output | 1 | A read instruction is waiting for input |
| in_data | input | DATA_W | Input stream value |
| out_valid | output | 1 | A write instruction is offering a value |
| out_ready | input | 1 | Output stream accepts the value |
| out_data | output | DATA_W | Output stream value |
| result | output | DATA_W | Register 0 |
| done | output | 1 | Execution has stopped (sticky) |

## Verification
The hardest cases to reach from the ports are the branch outcomes deep in a program. Examples are a copy followed by an equality jump, a zero test on a register that was just decremented from zero, and a fall past the end that is reached only after an undefined opcode. The bench loads one program whose write instructions expose each of these paths. It then picks inputs that steer every scenario down different branches: a sum that wraps, a saturating decrement, a halt versus running off the end, and an undefined opcode that would jump if it were decoded as one. Input gaps and masked output-ready patterns make reads and writes stall at different points in the program.

// File: rtl/cm_pkg.sv
package cm_pkg;
    localparam int INSTR_W = 24;
    localparam int OP_W    = 4;
    localparam int RF_W    = 3;
    localparam int OFF_W   = INSTR_W - OP_W - 2 * RF_W;
    localparam int NREG    = 2 ** RF_W;

    typedef enum logic [OP_W-1:0] {
        OP_CLR  = 4'd0,
        OP_INC  = 4'd1,
        OP_DEC  = 4'd2,
        OP_CPY  = 4'd3,
        OP_JZ   = 4'd4,
        OP_JE   = 4'd5,
        OP_JZD  = 4'd6,
        OP_JMP  = 4'd7,
        OP_RD   = 4'd8,
        OP_WR   = 4'd9,
        OP_HALT = 4'd10
    } op_e;

    typedef struct packed {
        op_e                     op;
        logic [RF_W-1:0]         ra;
        logic [RF_W-1:0]         rb;
        logic signed [OFF_W-1:0] off;
    } instr_t;

    function automatic logic signed [OFF_W-1:0] unit_step();
        return OFF_W'(1);
    endfunction
endpackage

// File: rtl/cm_fetch.sv
module cm_fetch
    import cm_pkg::*;
#(
    parameter int PROG_LEN = 6,
    parameter int PC_W     = 3,
    parameter logic [PROG_LEN*INSTR_W-1:0] PROG = '0
) (
    input  logic [PC_W-1:0] pc,
    output instr_t          ins
);
    logic [INSTR_W-1:0] rom [PROG_LEN];

    for (genvar g = 0; g < PROG_LEN; g++) begin : g_rom
        assign rom[g] = PROG[g*INSTR_W +: INSTR_W];
    end

    assign ins = instr_t'(rom[pc]);
endmodule

// File: rtl/cm_regfile.sv
module cm_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    localparam int AW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b,
    output logic [DATA_W-1:0] reg0
);
    logic [DATA_W-1:0] bank [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (we && waddr == AW'(g)) begin
                bank[g] <= wdata;
            end
        end
    end

    assign rdata_a = bank[raddr_a];
    assign rdata_b = bank[raddr_b];
    assign reg0    = bank[0];
endmodule

// File: rtl/cm_branch.sv
module cm_branch
    import cm_pkg::*;
#(
    parameter int PROG_LEN = 6,
    parameter int PC_W     = 3
) (
    input  logic [PC_W-1:0]         pc,
    input  logic signed [OFF_W-1:0] step,
    output logic [PC_W-1:0]         next_pc,
    output logic                    off_end
);
    localparam int T_W = ((PC_W > OFF_W) ? PC_W : OFF_W) + 2;
    localparam logic signed [T_W-1:0] LEN_S = T_W'(PROG_LEN);

    logic signed [T_W-1:0] tgt;

    assign tgt     = $signed({{(T_W-PC_W){1'b0}}, pc})
                   + $signed({{(T_W-OFF_W){step[OFF_W-1]}}, step});
    assign off_end = (tgt < 0) || (tgt >= LEN_S);
    assign next_pc = tgt[PC_W-1:0];
endmodule

// File: rtl/cm_seq.sv
module cm_seq
    import cm_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int PROG_LEN = 6,
    parameter logic [PROG_LEN*INSTR_W-1:0] PROG = {
        24'h900000, 24'h703FFE, 24'h100000,
        24'h620003, 24'h820000, 24'h800000},
    localparam int PC_W = $clog2(PROG_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [DATA_W-1:0] result,
    output logic              done
);
    logic [PC_W-1:0]         pc_q;
    logic                    done_q;
    instr_t                  ins;
    logic [DATA_W-1:0]       va, vb, wd;
    logic                    we, take, halt, stall, adv, off_end;
    logic signed [OFF_W-1:0] step;
    logic [PC_W-1:0]         next_pc;

    cm_fetch #(.PROG_LEN(PROG_LEN), .PC_W(PC_W), .PROG(PROG)) u_fetch (
        .pc (pc_q),
        .ins(ins)
    );

    cm_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (we && adv),
        .waddr  (ins.ra),
        .wdata  (wd),
        .raddr_a(ins.ra),
        .raddr_b(ins.rb),
        .rdata_a(va),
        .rdata_b(vb),
        .reg0   (result)
    );

    always_comb begin
        we   = 1'b0;
        wd   = va;
        take = 1'b0;
        halt = 1'b0;
        case (ins.op)
            OP_CLR:  begin we = 1'b1; wd = '0; end
            OP_INC:  begin we = 1'b1; wd = va + DATA_W'(1); end
            OP_DEC:  begin we = 1'b1; wd = (va == '0) ? '0 : va - DATA_W'(1); end
            OP_CPY:  begin we = 1'b1; wd = vb; end
            OP_JZ:   take = (va == '0);
            OP_JE:   take = (va == vb);
            OP_JZD:  begin
                take = (va == '0);
                we   = (va != '0);
                wd   = va - DATA_W'(1);
            end
            OP_JMP:  take = 1'b1;
            OP_RD:   begin we = 1'b1; wd = in_data; end
            OP_HALT: halt = 1'b1;
            default: ;
        endcase
    end

    assign stall = ((ins.op == OP_RD) && !in_valid) || ((ins.op == OP_WR) && !out_ready);
    assign adv   = !done_q && !stall;
    assign step  = take ? ins.off : unit_step();

    cm_branch #(.PROG_LEN(PROG_LEN), .PC_W(PC_W)) u_br (
        .pc     (pc_q),
        .step   (step),
        .next_pc(next_pc),
        .off_end(off_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            done_q <= 1'b0;
        end else if (adv) begin
            if (halt || off_end) begin
                done_q <= 1'b1;
            end else begin
                pc_q <= next_pc;
            end
        end
    end

    assign in_ready  = !done_q && (ins.op == OP_RD);
    assign out_valid = !done_q && (ins.op == OP_WR);
    assign out_data  = va;
    assign done      = done_q;
endmodule

// File: rtl/cm_seq_chk.sv
module cm_seq_chk #(
    parameter int DATA_W   = 16,
    parameter int PROG_LEN = 6,
    parameter int PC_W     = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [PC_W-1:0]   pc
);
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> done); // R7
    AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        !done |-> (int'(pc) < PROG_LEN)); // R7
    AST_READ_WAITS: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> in_ready); // R8
    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
    AST_QUIET_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (!in_ready && !out_valid)); // R12
    AST_ONE_STREAM: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid)); // R8
endmodule

bind cm_seq cm_seq_chk #(.DATA_W(DATA_W), .PROG_LEN(PROG_LEN), .PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .pc       (pc_q)
);

// File: tb/sim_cm_seq.sv
`timescale 1ns/100ps
module sim_cm_seq;
    localparam int PL = 22;
    localparam int DW = 16;

    function automatic logic [23:0] enc(int op, int ra, int rb, int off);
        return {4'(op), 3'(ra), 3'(rb), 14'(off)};
    endfunction

    function automatic logic [23:0] prog_at(int i);
        case (i)
            0:  return enc(8, 0, 0, 0);   // read r0
            1:  return enc(8, 1, 0, 0);   // read r1
            2:  return enc(6, 1, 0, 3);   // test-dec r1 -> 5
            3:  return enc(1, 0, 0, 0);   // inc r0
            4:  return enc(7, 0, 0, -2);  // jump back to 2
            5:  return enc(9, 0, 0, 0);   // write r0
            6:  return enc(8, 2, 0, 0);   // read r2
            7:  return enc(2, 2, 0, 0);   // dec r2
            8:  return enc(9, 2, 0, 0);   // write r2
            9:  return enc(3, 3, 2, 0);   // r3 := r2
            10: return enc(5, 3, 2, 2);   // equal -> 12
            11: return enc(9, 0, 0, 0);   // skipped write
            12: return enc(4, 2, 0, 3);   // r2 zero -> 15
            13: return enc(0, 2, 0, 0);   // clear r2
            14: return enc(9, 2, 0, 0);   // write r2
            15: return enc(1, 2, 0, 0);   // inc r2
            16: return enc(9, 2, 0, 0);   // write r2
            17: return enc(8, 4, 0, 0);   // read r4
            18: return enc(4, 4, 0, 2);   // r4 zero -> 20
            19: return enc(10, 0, 0, 0);  // halt
            20: return enc(11, 4, 0, 5);  // undefined op
            21: return enc(9, 4, 0, 0);   // write r4, then off the end
            default: return '0;
        endcase
    endfunction

    function automatic logic [PL*24-1:0] build();
        logic [PL*24-1:0] v;
        v = '0;
        for (int i = 0; i < PL; i++) v[i*24 +: 24] = prog_at(i);
        return v;
    endfunction

    localparam logic [PL*24-1:0] PROG = build();

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic [DW-1:0] result;
    logic          done;

    int     errors = 0;
    int     checks = 0;
    int     cyc = 0;
    logic [3:0] rmask = 4'hF;
    int     exp_q[$];
    string  tag_q[$];

    always #2.5 clk = ~clk;

    cm_seq #(.DATA_W(DW), .PROG_LEN(PL), .PROG(PROG)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .result(result), .done(done)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks + 1);
                $finish;
            end
        end
    end

    // monitor: pops expected outputs as handshakes happen
    initial begin
        bit   held = 1'b0;
        logic [DW-1:0] held_d = '0;
        forever begin
            @(negedge clk);
            out_ready = rmask[cyc % 4];
            #1;
            if (held) begin
                check(out_valid && out_data == held_d, "R9", "stalled write held",
                      int'(out_data), int'(held_d));
            end
            held = 1'b0;
            if (!rst && out_valid && !out_ready) begin
                held   = 1'b1;
                held_d = out_data;
            end
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12", "unexpected output", int'(out_data), -1);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(int'(out_data) == e, t, "output value", int'(out_data), e);
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(result == '0, "R1", "result after reset", int'(result), 0);
    endtask

    task automatic feed(logic [DW-1:0] v, int gap, bit first);
        for (int k = 0; k < gap; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            #1;
            if (first) check(in_ready == 1'b1, "R8", "read waits for valid", int'(in_ready), 1);
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_case(int x, int y, int z, int w, int gap, logic [3:0] m);
        int sum, sz, n;
        sum = (x + y) & 16'hFFFF;
        sz  = (z == 0) ? 0 : z - 1;
        do_reset();
        rmask = m;
        exp_q.push_back(sum); tag_q.push_back("R6");
        exp_q.push_back(sz);  tag_q.push_back("R3");
        if (sz != 0) begin exp_q.push_back(0); tag_q.push_back("R4"); end
        exp_q.push_back(1); tag_q.push_back("R5");
        if (w == 0) begin exp_q.push_back(0); tag_q.push_back("R11"); end
        feed(DW'(x), gap, 1'b1);
        feed(DW'(y), gap, 1'b0);
        feed(DW'(z), gap, 1'b0);
        feed(DW'(w), gap, 1'b0);
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            #1;
            n++;
        end
        check(done == 1'b1, "R7", "stopped", int'(done), 1);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R7", "all outputs seen", exp_q.size(), 0);
        check(int'(result) == sum, "R10", "result is r0", int'(result), sum);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 16'h5A5A;
            #1;
            check(!in_ready && !out_valid, "R12", "no stream activity after done",
                  int'({in_ready, out_valid}), 0);
        end
        in_valid = 1'b0;
        check(done == 1'b1, "R7", "done sticky", int'(done), 1);
        check(int'(result) == sum, "R12", "result untouched after done", int'(result), sum);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        run_case(3, 4, 0, 5, 0, 4'b1111);        // R2 halt path, R3 dec of zero
        run_case(16'hFFFF, 2, 1, 0, 3, 4'b0101); // R2 wrap, R11 undefined op
        run_case(10, 0, 7, 0, 1, 4'b0011);       // R6 zero count, R4 copy path
        run_case(0, 0, 2, 9, 2, 4'b1001);        // R5 branches, R1 reset again
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule